// File: doc/BRIEF.md
# SPI NOR Flash Command Front-End

This block is the serial slave front-end of a small SPI NOR memory. It oversamples the serial clock, chip select and data-in lines with the system clock. It shifts in an opcode byte, optional address bytes and an optional dummy byte, most significant bit first on rising SCLK, and drives SO on falling SCLK. Commands that change the device are reported on a strobe with an operation code and the captured address. Data bytes for page program and write-status are handed out one at a time as they arrive.

For the read class, the block streams bytes from an external read port with an address that advances by one per byte. It also serves the status byte, which is supplied from outside, and two fixed identification sequences. The storage array, the status rules and the program buffer lie outside the block. The block reaches them through the read port, the busy input, the command strobe and the data strobe. A write-class command is committed only when chip select rises after a whole number of bytes. Memory and ID reads are refused while the device is busy, but status reads are always served.

Top module: `spinor_fe`

## Requirements
- R1: Bits on `spi_si` are taken on rising SCLK, MSB first, and the first byte after chip select falls is the opcode. SPI mode 0 (SCLK idle low) and mode 3 (SCLK idle high) both work.
- R2: `spi_so` changes only after a falling SCLK edge, MSB first. `spi_so_oe` is high only during a data-out phase with chip select low, and it is low during and after reset.
- R3: The single-byte commands 06h, 04h, C7h and 60h raise `cmd_valid` for one cycle after chip select rises. `cmd_op` is 0 for 06h, 1 for 04h and 6 for both erase-all codes.
- R4: For 20h and D8h, three address bytes follow the opcode. After chip select rises, `cmd_valid` gives `cmd_op` 4 or 5 and `cmd_addr` holds the 24-bit address.
- R5: A write-class command is dropped if chip select rises when the SCLK count is not a multiple of eight. It is also dropped if the command is incomplete or has extra bytes.
- R6: For 02h, each data byte after the three address bytes appears on `wr_data` with a one-cycle `wr_valid`. The command commits as `cmd_op` 3 with the start address only if at least one full data byte arrived.
- R7: For 01h, exactly one data byte follows. It appears on `wr_data`, and the command commits as `cmd_op` 2.
- R8: 03h with a 24-bit address streams read-port bytes starting at that address. The address advances by one after each byte and wraps at 24 bits, and the read may end after any bit.
- R9: 0Bh behaves like 03h, except that one dummy byte is taken after the address before data comes out.
- R10: 05h returns `status_byte` and repeats it for as long as clocks continue, even while `busy` is high.
- R11: 9Fh returns 0Eh, 40h, 13h and then repeats. 90h with an address returns 0Eh and 12h alternately, starting with 12h when address bit 0 is 1.
- R12: A 03h, 0Bh, 90h or 9Fh opcode that completes while `busy` is high is ignored: `spi_so_oe` stays low for the rest of that selection.
- R13: An unknown opcode causes no output and no strobes until chip select rises, and the next command then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 6x the SCLK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO |
| busy | input | 1 | Program/erase/status-write cycle running |
| status_byte | input | 8 | Status value returned by 05h |
| rd_addr | output | 24 | Read-port address |
| rd_en | output | 1 | Read port in use |
| rd_data | input | 8 | Read-port data for `rd_addr`, combinational |
| cmd_valid | output | 1 | One-cycle committed-command strobe |
| cmd_op | output | 3 | Committed operation code |
| cmd_addr | output | 24 | Address captured for the command |
| wr_valid | output | 1 | One-cycle data-byte strobe |
| wr_data | output | 8 | Data byte for program or status write |

## Verification
Every command is driven in both SPI modes. Mode 0 and mode 3 differ only in the idle clock level, so a fault in edge detection shows up as a mode-specific failure. Reads are swept over start addresses that cross byte and 24-bit carry boundaries, which separates correct incrementing from stuck or skipped addresses. Truncated, overlong and bit-misaligned write sequences are each sent alongside a correct one, so that a commit which ignores the byte-boundary rule is caught. Busy-time memory reads, ID reads and status reads are compared to show that only the status read is served.

// File: rtl/spinor_fe_pkg.sv
// Shared opcodes, command codes and state types for the SPI NOR front-end.
package spinor_fe_pkg;
    localparam int BYTE_BITS = 8;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_FREAD = 8'h0B;
    localparam logic [7:0] OPC_PP    = 8'h02;
    localparam logic [7:0] OPC_SE    = 8'h20;
    localparam logic [7:0] OPC_BE    = 8'hD8;
    localparam logic [7:0] OPC_CE1   = 8'hC7;
    localparam logic [7:0] OPC_CE2   = 8'h60;
    localparam logic [7:0] OPC_MID   = 8'h90;
    localparam logic [7:0] OPC_JID   = 8'h9F;

    typedef enum logic [2:0] {
        CMD_WREN = 3'd0, CMD_WRDI = 3'd1, CMD_WRSR = 3'd2, CMD_PP = 3'd3,
        CMD_SE = 3'd4, CMD_BE = 3'd5, CMD_CE = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        ST_OP, ST_ADDR, ST_DUMMY, ST_OUT, ST_DIN, ST_HOLD, ST_SKIP
    } st_e;

    typedef enum logic [1:0] {
        SRC_STAT, SRC_MEM, SRC_JID, SRC_MID
    } src_e;
endpackage

// File: rtl/spinor_fe_rx.sv
// Oversamples SCLK, CS# and SI in the system clock domain, finds edges,
// and assembles MSB-first bytes. Assumes the inputs are already synchronous
// and that SCLK stays in each level for at least three system clocks.
module spinor_fe_rx
    import spinor_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 si,
    output logic                 sel,
    output logic                 cs_rise,
    output logic                 sclk_rise,
    output logic                 sclk_fall,
    output logic                 aligned,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_data
);
    localparam int CNT_W = $clog2(BYTE_BITS);

    logic             s_sclk, p_sclk, s_cs_n, p_cs_n, s_si;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_BITS-2:0] shreg;

    // Sample pins and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_sclk <= 1'b0; p_sclk <= 1'b0;
            s_cs_n <= 1'b1; p_cs_n <= 1'b1;
            s_si   <= 1'b0;
        end else begin
            s_sclk <= sclk; p_sclk <= s_sclk;
            s_cs_n <= cs_n; p_cs_n <= s_cs_n;
            s_si   <= si;
        end
    end

    assign sel       = !s_cs_n;
    assign cs_rise   = s_cs_n && !p_cs_n;
    assign sclk_rise = s_sclk && !p_sclk;
    assign sclk_fall = !s_sclk && p_sclk;

    // Count bits and shift data while selected; clear on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sclk_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[BYTE_BITS-3:0], s_si};
        end
    end

    assign aligned    = (bit_cnt == '0);
    assign byte_valid = sel && sclk_rise && (bit_cnt == CNT_W'(BYTE_BITS-1));
    assign byte_data  = {shreg, s_si};
endmodule

// File: rtl/spinor_fe_tx.sv
// Serialises bytes MSB first on falling SCLK. It samples tx_byte at the
// first falling edge of each byte and pulses take at that edge, so the
// byte source may step to its next byte.
module spinor_fe_tx
    import spinor_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 sclk_fall,
    input  logic [BYTE_BITS-1:0] tx_byte,
    output logic                 so,
    output logic                 take
);
    localparam int CNT_W = $clog2(BYTE_BITS);

    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-2:0] shreg;

    assign take = en && sclk_fall && (cnt == '0);

    // Shift out one bit per falling edge; reload at each byte start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; shreg <= '0; so <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
        end else if (sclk_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == '0) {so, shreg} <= tx_byte;
            else           {so, shreg} <= {shreg, 1'b0};
        end
    end

    AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so) |-> $past(sclk_fall)); // R2
endmodule

// File: rtl/spinor_fe_ctrl.sv
// Command state machine: decodes opcodes, collects the address, picks the
// output byte source, and commits write-class commands only when CS# rises
// on a byte boundary. Assumes a combinational read port (rd_data follows
// rd_addr in the same cycle).
module spinor_fe_ctrl
    import spinor_fe_pkg::*;
#(
    parameter int         ADDR_BYTES = 3,
    parameter logic [7:0] MFR_ID     = 8'h0E,
    parameter logic [7:0] MEM_TYPE   = 8'h40,
    parameter logic [7:0] MEM_CAP    = 8'h13,
    parameter logic [7:0] DEV_ID     = 8'h12,
    localparam int        ADDR_W     = ADDR_BYTES * BYTE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 cs_rise,
    input  logic                 aligned,
    input  logic                 byte_valid,
    input  logic [BYTE_BITS-1:0] byte_data,
    input  logic                 take,
    input  logic                 busy,
    input  logic [BYTE_BITS-1:0] status_byte,
    input  logic [BYTE_BITS-1:0] rd_data,
    output logic                 out_en,
    output logic [BYTE_BITS-1:0] tx_byte,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_en,
    output logic                 cmd_valid,
    output logic [2:0]           cmd_op,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic                 wr_valid,
    output logic [BYTE_BITS-1:0] wr_data
);
    localparam int ACNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    st_e               state;
    src_e              src;
    cmd_e              pend;
    logic [7:0]        op;
    logic [ACNT_W-1:0] acnt;
    logic [ADDR_W-1:0] addr_sh;
    logic [ADDR_W-1:0] full_addr;
    logic [1:0]        id_idx;
    logic              got_data;

    assign full_addr = {addr_sh[ADDR_W-BYTE_BITS-1:0], byte_data};
    assign out_en    = sel && (state == ST_OUT);
    assign rd_en     = out_en && (src == SRC_MEM);
    assign cmd_addr  = addr_sh;

    // Select the byte offered to the serialiser.
    always_comb begin
        case (src)
            SRC_STAT: tx_byte = status_byte;
            SRC_MEM:  tx_byte = rd_data;
            SRC_JID:  tx_byte = (id_idx == 2'd0) ? MFR_ID :
                                (id_idx == 2'd1) ? MEM_TYPE : MEM_CAP;
            default:  tx_byte = id_idx[0] ? DEV_ID : MFR_ID;
        endcase
    end

    // Sequence the command phases and emit strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OP; src <= SRC_STAT; pend <= CMD_WREN; op <= '0;
            acnt <= '0; addr_sh <= '0; rd_addr <= '0; id_idx <= '0;
            got_data <= 1'b0; cmd_valid <= 1'b0; cmd_op <= '0;
            wr_valid <= 1'b0; wr_data <= '0;
        end else begin
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;
            if (!sel) begin
                if (cs_rise && aligned) begin
                    if (state == ST_HOLD) begin
                        cmd_valid <= 1'b1; cmd_op <= pend;
                    end else if (state == ST_DIN && op == OPC_PP && got_data) begin
                        cmd_valid <= 1'b1; cmd_op <= CMD_PP;
                    end
                end
                state <= ST_OP; acnt <= '0; got_data <= 1'b0;
            end else if (byte_valid) begin
                case (state)
                    ST_OP: begin
                        op <= byte_data;
                        case (byte_data)
                            OPC_WREN: begin pend <= CMD_WREN; state <= ST_HOLD; end
                            OPC_WRDI: begin pend <= CMD_WRDI; state <= ST_HOLD; end
                            OPC_CE1, OPC_CE2: begin pend <= CMD_CE; state <= ST_HOLD; end
                            OPC_RDSR: begin src <= SRC_STAT; state <= ST_OUT; end
                            OPC_WRSR: state <= ST_DIN;
                            OPC_PP, OPC_SE, OPC_BE: state <= ST_ADDR;
                            OPC_READ, OPC_FREAD, OPC_MID:
                                state <= busy ? ST_SKIP : ST_ADDR;
                            OPC_JID: begin
                                src <= SRC_JID; id_idx <= 2'd0;
                                state <= busy ? ST_SKIP : ST_OUT;
                            end
                            default: state <= ST_SKIP;
                        endcase
                    end
                    ST_ADDR: begin
                        addr_sh <= full_addr;
                        acnt    <= acnt + 1'b1;
                        if (acnt == ACNT_W'(ADDR_BYTES-1)) begin
                            case (op)
                                OPC_READ:  begin rd_addr <= full_addr; src <= SRC_MEM; state <= ST_OUT; end
                                OPC_FREAD: begin rd_addr <= full_addr; state <= ST_DUMMY; end
                                OPC_PP:    state <= ST_DIN;
                                OPC_SE:    begin pend <= CMD_SE; state <= ST_HOLD; end
                                OPC_BE:    begin pend <= CMD_BE; state <= ST_HOLD; end
                                default:   begin src <= SRC_MID; id_idx <= {1'b0, full_addr[0]}; state <= ST_OUT; end
                            endcase
                        end
                    end
                    ST_DUMMY: begin src <= SRC_MEM; state <= ST_OUT; end
                    ST_DIN: begin
                        wr_valid <= 1'b1; wr_data <= byte_data;
                        if (op == OPC_WRSR) begin pend <= CMD_WRSR; state <= ST_HOLD; end
                        else got_data <= 1'b1;
                    end
                    ST_HOLD: state <= ST_SKIP;
                    default: ;
                endcase
            end else if (take && state == ST_OUT) begin
                case (src)
                    SRC_MEM: rd_addr <= rd_addr + 1'b1;
                    SRC_JID: id_idx  <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
                    SRC_MID: id_idx  <= {1'b0, ~id_idx[0]};
                    default: ;
                endcase
            end
        end
    end

    AST_COMMIT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(aligned) && $past(cs_rise))); // R5
    AST_NO_CMD_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && wr_valid)); // R6
    AST_BUSY_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OP && byte_valid && busy && byte_data == OPC_READ) |=> !out_en); // R12
endmodule

// File: rtl/spinor_fe.sv
// Top of the SPI NOR command front-end: input sampler, command sequencer
// and output serialiser. Assumes clk runs at least six times faster than SCLK.
module spinor_fe
    import spinor_fe_pkg::*;
#(
    parameter int         ADDR_BYTES = 3,
    parameter logic [7:0] MFR_ID     = 8'h0E,
    parameter logic [7:0] MEM_TYPE   = 8'h40,
    parameter logic [7:0] MEM_CAP    = 8'h13,
    parameter logic [7:0] DEV_ID     = 8'h12,
    localparam int        ADDR_W     = ADDR_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              busy,
    input  logic [7:0]        status_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    input  logic [7:0]        rd_data,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_valid,
    output logic [7:0]        wr_data
);
    logic       sel, cs_rise, sclk_rise, sclk_fall, aligned, byte_valid, take;
    logic [7:0] byte_data, tx_byte;

    spinor_fe_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .si(spi_si),
        .sel(sel), .cs_rise(cs_rise), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .aligned(aligned), .byte_valid(byte_valid), .byte_data(byte_data)
    );

    spinor_fe_ctrl #(
        .ADDR_BYTES(ADDR_BYTES), .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE),
        .MEM_CAP(MEM_CAP), .DEV_ID(DEV_ID)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cs_rise(cs_rise), .aligned(aligned),
        .byte_valid(byte_valid), .byte_data(byte_data), .take(take), .busy(busy),
        .status_byte(status_byte), .rd_data(rd_data), .out_en(spi_so_oe),
        .tx_byte(tx_byte), .rd_addr(rd_addr), .rd_en(rd_en), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data)
    );

    spinor_fe_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(spi_so_oe), .sclk_fall(sclk_fall),
        .tx_byte(tx_byte), .so(spi_so), .take(take)
    );

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_so_oe |-> !$past(spi_cs_n)); // R2
    AST_CMD_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(spi_cs_n, 2)); // R3
    AST_DATA_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(spi_cs_n, 2)); // R6
endmodule

// File: tb/spinor_fe_test.sv
module spinor_fe_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, si = 1'b0, so, so_oe;
    logic        busy = 1'b0;
    logic [7:0]  status = 8'h00;
    logic [23:0] rd_addr, cmd_addr;
    logic        rd_en, cmd_valid, wr_valid;
    logic [7:0]  rd_data, wr_data;
    logic [2:0]  cmd_op;

    int errors = 0, checks = 0;
    int ncmd = 0, nwr = 0;
    logic [2:0]  last_op;
    logic [23:0] last_addr;
    logic [7:0]  wbuf [0:31];
    logic        mode3 = 1'b0, oe_seen = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    assign rd_data = memf(rd_addr);

    spinor_fe uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .busy(busy), .status_byte(status),
        .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data)
    );

    // Record strobes from the block.
    always @(posedge clk) begin
        if (rst_n && cmd_valid) begin ncmd <= ncmd + 1; last_op <= cmd_op; last_addr <= cmd_addr; end
        if (rst_n && wr_valid)  begin wbuf[nwr % 32] <= wr_data; nwr <= nwr + 1; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic halfp(); repeat (4) @(negedge clk); endtask

    task automatic spi_start();
        @(negedge clk); sclk = mode3; oe_seen = 1'b0; halfp();
        cs_n = 1'b0; halfp();
    endtask

    task automatic spi_bit(input logic b, output logic r);
        @(negedge clk); sclk = 1'b0; si = b; halfp();
        sclk = 1'b1; r = so_oe ? so : 1'b0;
        if (so_oe) oe_seen = 1'b1;
        halfp();
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
    endtask

    task automatic spi_tx(input logic [7:0] b);
        logic [7:0] r;
        spi_byte(b, r);
    endtask

    task automatic spi_bits(input logic [7:0] b, input int n);
        logic r;
        for (int i = 7; i > 7 - n; i--) spi_bit(b[i], r);
    endtask

    task automatic spi_stop();
        @(negedge clk); if (!mode3) sclk = 1'b0; halfp();
        cs_n = 1'b1; halfp(); halfp();
    endtask

    task automatic send_addr(input logic [23:0] a);
        spi_tx(a[23:16]); spi_tx(a[15:8]); spi_tx(a[7:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n0, w0;
        logic [7:0] r;
        logic [23:0] a;
        repeat (5) @(negedge clk);
        chk("R2 oe low in reset", so_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 oe low after reset", so_oe, 0);
        chk("R3 no strobe after reset", ncmd, 0);

        for (int m = 0; m < 2; m++) begin
            mode3 = m[0];
            // R3 single-byte commands
            n0 = ncmd; spi_start(); spi_tx(8'h06); spi_stop();
            chk("R3 R1 WREN count", ncmd, n0 + 1); chk("R3 R1 WREN op", last_op, 0);
            spi_start(); spi_tx(8'h04); spi_stop();
            chk("R3 WRDI op", last_op, 1);
            spi_start(); spi_tx(8'hC7); spi_stop();
            chk("R3 CE C7 op", last_op, 6);
            n0 = ncmd; spi_start(); spi_tx(8'h60); spi_stop();
            chk("R3 CE 60 count", ncmd, n0 + 1); chk("R3 CE 60 op", last_op, 6);
            // R4 erases with address
            spi_start(); spi_tx(8'h20); send_addr(24'h012345 + m); spi_stop();
            chk("R4 R1 SE op", last_op, 4); chk("R4 R1 SE addr", last_addr, 24'h012345 + m);
            spi_start(); spi_tx(8'hD8); send_addr(24'hFEDCBA); spi_stop();
            chk("R4 BE op", last_op, 5); chk("R4 BE addr", last_addr, 24'hFEDCBA);
            // R5 misaligned, overlong, short
            n0 = ncmd; spi_start(); spi_tx(8'h06); spi_bits(8'hFF, 3); spi_stop();
            chk("R5 WREN plus 3 bits rejected", ncmd, n0);
            spi_start(); spi_tx(8'h06); spi_tx(8'h00); spi_stop();
            chk("R5 WREN plus byte rejected", ncmd, n0);
            spi_start(); spi_tx(8'h20); spi_tx(8'h01); spi_tx(8'h02); spi_stop();
            chk("R5 SE short address rejected", ncmd, n0);
            spi_start(); spi_bits(8'hC7, 5); spi_stop();
            chk("R5 partial opcode rejected", ncmd, n0);
            // R6 page program
            n0 = ncmd; w0 = nwr;
            spi_start(); spi_tx(8'h02); send_addr(24'h0000F0);
            for (int k = 0; k < 3; k++) spi_tx(8'h11 * (k + 1));
            spi_stop();
            chk("R6 PP data count", nwr, w0 + 3);
            for (int k = 0; k < 3; k++) chk("R6 PP data byte", wbuf[(w0 + k) % 32], 8'h11 * (k + 1));
            chk("R6 PP op", last_op, 3); chk("R6 PP addr", last_addr, 24'h0000F0);
            n0 = ncmd; spi_start(); spi_tx(8'h02); send_addr(24'h000100); spi_stop();
            chk("R6 PP no data rejected", ncmd, n0);
            spi_start(); spi_tx(8'h02); send_addr(24'h000100); spi_tx(8'hAA); spi_bits(8'h55, 4); spi_stop();
            chk("R6 PP partial byte rejected", ncmd, n0);
            // R7 write status
            w0 = nwr; spi_start(); spi_tx(8'h01); spi_tx(8'h9C); spi_stop();
            chk("R7 WRSR data", wbuf[w0 % 32], 8'h9C); chk("R7 WRSR op", last_op, 2);
            chk("R7 WRSR count", ncmd, n0 + 1);
            n0 = ncmd; spi_start(); spi_tx(8'h01); spi_stop();
            chk("R7 WRSR without data rejected", ncmd, n0);
            // R8 read sweep
            for (int k = 0; k < 8; k++) begin
                a = (k == 0) ? 24'hFFFFFE : 24'h00FFFD + 24'(k) * 24'h01F3;
                spi_start(); spi_tx(8'h03); send_addr(a);
                for (int j = 0; j < 4; j++) begin
                    spi_byte(8'h00, r);
                    chk("R8 read byte", r, memf(a + 24'(j)));
                end
                spi_stop();
            end
            spi_start(); spi_tx(8'h03); send_addr(24'h000010); spi_bits(8'h00, 3); spi_stop();
            status = 8'h5C;
            spi_start(); spi_tx(8'h05); spi_byte(8'h00, r); spi_stop();
            chk("R8 end mid-byte then status", r, 8'h5C);
            // R9 fast read
            spi_start(); spi_tx(8'h0B); send_addr(24'h00ABFF); spi_tx(8'hFF);
            for (int j = 0; j < 3; j++) begin
                spi_byte(8'h00, r);
                chk("R9 fast read byte", r, memf(24'h00ABFF + 24'(j)));
            end
            spi_stop();
            // R10 status while busy
            busy = 1'b1; status = 8'h83;
            spi_start(); spi_tx(8'h05);
            for (int j = 0; j < 3; j++) begin spi_byte(8'h00, r); chk("R10 status repeat", r, 8'h83); end
            spi_stop();
            // R12 refused while busy
            spi_start(); spi_tx(8'h03); send_addr(24'h000000); spi_byte(8'h00, r); spi_stop();
            chk("R12 read refused oe", oe_seen, 0);
            spi_start(); spi_tx(8'h0B); send_addr(24'h0); spi_tx(8'h00); spi_byte(8'h00, r); spi_stop();
            chk("R12 fast read refused oe", oe_seen, 0);
            spi_start(); spi_tx(8'h9F); spi_byte(8'h00, r); spi_stop();
            chk("R12 id refused oe", oe_seen, 0);
            busy = 1'b0;
            // R11 identification
            spi_start(); spi_tx(8'h9F);
            for (int j = 0; j < 6; j++) begin
                spi_byte(8'h00, r);
                chk("R11 jedec id", r, (j % 3 == 0) ? 8'h0E : (j % 3 == 1) ? 8'h40 : 8'h13);
            end
            spi_stop();
            for (int s = 0; s < 2; s++) begin
                spi_start(); spi_tx(8'h90); send_addr(24'(s));
                for (int j = 0; j < 3; j++) begin
                    spi_byte(8'h00, r);
                    chk("R11 mfr dev id", r, (((j + s) % 2) == 0) ? 8'h0E : 8'h12);
                end
                spi_stop();
            end
            // R13 unknown opcode
            n0 = ncmd; w0 = nwr;
            spi_start(); spi_tx(8'hAB); spi_tx(8'h02); spi_tx(8'h06); spi_stop();
            chk("R13 unknown no cmd", ncmd, n0);
            chk("R13 unknown no data", nwr, w0);
            chk("R13 unknown no output", oe_seen, 0);
            spi_start(); spi_tx(8'h04); spi_stop();
            chk("R13 next command works", ncmd, n0 + 1);
            chk("R2 oe low when deselected", so_oe, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule